// File: doc/BRIEF.md
# Amplifier Diagnostic Interrupt Aggregator

This block gathers the fault and status flags of a four-channel power amplifier and turns them into two active-low pin levels. The first pin is a diagnostic line that a host processor can use as an interrupt. The second pin is the standby line, which can be reused as a second clip indicator. Every flag input is asynchronous to the block clock, so each one passes through a two-stage synchronizer. Both pin levels leave the block from flip-flops.

Some contributors always pull the diagnostic pin low: supply undervoltage, supply overvoltage, the overvoltage protection flag and a sticky power-up condition. The sticky power-up condition holds the pin low until the amplifier reports that it has started. Thermal pre-warning, output short and missing-current protection contribute only when their enable bit is set. Each channel's clip flag can be steered to the diagnostic pin, to the standby pin, to both, or to neither. This allows, for example, front and rear clipping to be told apart.

A mode input selects legacy operation. In legacy mode a fixed set of flags drives the diagnostic pin with no masking, the power-up condition is hidden, and the standby pin only follows its control level. Configuration arrives through a plain parallel write port.

Top module: `amp_diag_agg`

## Requirements
- R1: While `rst` is high, `diag_n` is 0 and `stby_n` is 1. All enable bits and routing fields are cleared to 0, and the sticky power-up hold is set.
- R2: A change on a flag input reaches `diag_n` at the third rising edge after it is applied, and not earlier. `diag_n` returns to 1 as soon as no contributing condition remains.
- R3: In normal (non-legacy) mode, `lobat_flag`, `hibat_flag` and `ovp_flag` each drive `diag_n` low whatever the enable bits hold.
- R4: In normal mode, a power-up hold drives `diag_n` low. The hold is set by reset or by `por_flag`, and it clears only once `amp_started` is seen high while `por_flag` is low.
- R5: Enable register (address 0): bit 0 lets `tempw_flag` contribute, bit 1 lets `short_flag` contribute, and bit 2 lets `misscur_flag` contribute. A disabled flag has no effect on `diag_n`.
- R6: When enable bit 3 is set in normal mode, `stby_n` is 0 exactly when some clipping channel is routed to the standby pin.
- R7: Routing register (address 1) holds two bits per channel c, at bits [2c+1:2c]. The low bit sends the clip of channel c to `diag_n` and the high bit sends it to the standby pin. So 00 is off, 01 is diagnostic, 10 is standby and 11 is both.
- R8: In legacy mode, `diag_n` is low when any of these is high: the undervoltage, overvoltage, protection, pre-warning, short or missing-current flag, or any channel's clip flag. No enable or route is applied, and the power-up hold is not shown.
- R9: In legacy mode, or when enable bit 3 is clear, `stby_n` follows `standby_ctrl`, with the same three-edge delay as the flags.
- R10: A configuration write is taken at the rising edge where `cfg_we` is high. It affects the pins at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | 1 selects legacy fixed-mask mode |
| standby_ctrl | input | 1 | Standby level passed to `stby_n` when it is not a clip output |
| amp_started | input | 1 | Amplifier has finished start-up |
| por_flag | input | 1 | Power-on reset seen |
| lobat_flag | input | 1 | Supply undervoltage |
| hibat_flag | input | 1 | Supply overvoltage |
| ovp_flag | input | 1 | Overvoltage protection active |
| tempw_flag | input | 1 | Thermal pre-warning |
| short_flag | input | 1 | Output short or load fault |
| misscur_flag | input | 1 | Speaker protection, missing current |
| clip_flag | input | NUM_CH | Per-channel clip detect |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 = enable register, 1 = routing register |
| cfg_wdata | input | CFG_DW | Configuration write data |
| diag_n | output | 1 | Active-low diagnostic / interrupt level |
| stby_n | output | 1 | Active-low standby level or second clip output |

## Verification
A flag or mode change crosses two synchronizer stages and one output register. Its result is therefore due at the third rising edge after it is driven on a falling edge. The bench waits exactly three rising edges and samples on the following falling edge. A directed case also samples after only two edges, to show that the old level still holds there. A configuration write passes one register before the output register, so the bench samples one edge after the write edge and expects the old level, then samples one edge later and expects the new one. Each table vector writes both configuration registers before it changes the flags, so that the configuration has settled before the three-edge flag window starts.

// File: rtl/diag_pkg.sv
package diag_pkg;

  // Number of non-clip signals in the synchronized input vector
  localparam int FIXED_FLAGS = 10;

  // Offsets of the fixed signals above the clip bits in the raw vector
  localparam int OFS_MISSCUR = 0;
  localparam int OFS_SHORT   = 1;
  localparam int OFS_TEMPW   = 2;
  localparam int OFS_OVP     = 3;
  localparam int OFS_HIBAT   = 4;
  localparam int OFS_LOBAT   = 5;
  localparam int OFS_POR     = 6;
  localparam int OFS_STARTED = 7;
  localparam int OFS_STBY    = 8;
  localparam int OFS_LEGACY  = 9;

  // Configuration addresses
  localparam logic CFG_ADDR_ENABLE = 1'b0;
  localparam logic CFG_ADDR_ROUTE  = 1'b1;

  // Enable register bit positions
  localparam int EN_W         = 4;
  localparam int EN_TEMPW     = 0;
  localparam int EN_SHORT     = 1;
  localparam int EN_MISSCUR   = 2;
  localparam int EN_STBY_CLIP = 3;

  // Routing pair bit positions within each channel's two-bit field
  localparam int RT_DIAG = 0;
  localparam int RT_STBY = 1;

  typedef struct packed {
    logic legacy;
    logic stby_lvl;
    logic started;
    logic por;
    logic lobat;
    logic hibat;
    logic ovp;
    logic tempw;
    logic shrt;
    logic misscur;
  } diag_flags_t;

endpackage

// File: rtl/diag_sync.sv
module diag_sync #(
  parameter int W      = 14,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/diag_cfg_regs.sv
module diag_cfg_regs
  import diag_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CFG_DW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic                addr,
  input  logic [CFG_DW-1:0]   wdata,
  output logic [EN_W-1:0]     en_q,
  output logic [2*NUM_CH-1:0] route_q
);

  localparam int ROUTE_W = 2 * NUM_CH;

  // CFG_DW must cover both EN_W and ROUTE_W
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      route_q <= '0;
    end else if (we) begin
      if (addr == CFG_ADDR_ENABLE) en_q    <= wdata[EN_W-1:0];
      else                         route_q <= wdata[ROUTE_W-1:0];
    end
  end

endmodule

// File: rtl/diag_clip_router.sv
module diag_clip_router
  import diag_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0]   clip,
  input  logic [2*NUM_CH-1:0] route,
  output logic                to_diag,
  output logic                to_stby
);

  logic [NUM_CH-1:0] diag_hit;
  logic [NUM_CH-1:0] stby_hit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign diag_hit[c] = clip[c] & route[2*c + RT_DIAG];
    assign stby_hit[c] = clip[c] & route[2*c + RT_STBY];
  end

  assign to_diag = |diag_hit;
  assign to_stby = |stby_hit;

endmodule

// File: rtl/diag_por_tracker.sv
module diag_por_tracker (
  input  logic clk,
  input  logic rst,
  input  logic por_s,
  input  logic started_s,
  output logic por_active,
  output logic por_hold_q
);

  assign por_active = por_s | (por_hold_q & ~started_s);

  always_ff @(posedge clk) begin
    if (rst) por_hold_q <= 1'b1;
    else     por_hold_q <= por_active;
  end

endmodule

// File: rtl/amp_diag_agg.sv
module amp_diag_agg
  import diag_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CFG_DW      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              legacy_mode,
  input  logic              standby_ctrl,
  input  logic              amp_started,
  input  logic              por_flag,
  input  logic              lobat_flag,
  input  logic              hibat_flag,
  input  logic              ovp_flag,
  input  logic              tempw_flag,
  input  logic              short_flag,
  input  logic              misscur_flag,
  input  logic [NUM_CH-1:0] clip_flag,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic              diag_n,
  output logic              stby_n
);

  localparam int ROUTE_W = 2 * NUM_CH;
  localparam int IN_W    = NUM_CH + FIXED_FLAGS;

  logic [IN_W-1:0]    raw_in;
  logic [IN_W-1:0]    sync_in;
  diag_flags_t        flg_s;
  logic [NUM_CH-1:0]  clip_s;
  logic [EN_W-1:0]    en_q;
  logic [ROUTE_W-1:0] route_q;
  logic               clip_to_diag;
  logic               clip_to_stby;
  logic               por_active;
  logic               por_hold_q;
  logic               bus_fault;
  logic               legacy_fault;
  logic               fault;
  logic               stby_clip_mode;
  logic               stby_next;

  assign raw_in = {legacy_mode, standby_ctrl, amp_started, por_flag,
                   lobat_flag, hibat_flag, ovp_flag, tempw_flag,
                   short_flag, misscur_flag, clip_flag};

  diag_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_in)
  );

  assign clip_s         = sync_in[NUM_CH-1:0];
  assign flg_s.misscur  = sync_in[NUM_CH + OFS_MISSCUR];
  assign flg_s.shrt     = sync_in[NUM_CH + OFS_SHORT];
  assign flg_s.tempw    = sync_in[NUM_CH + OFS_TEMPW];
  assign flg_s.ovp      = sync_in[NUM_CH + OFS_OVP];
  assign flg_s.hibat    = sync_in[NUM_CH + OFS_HIBAT];
  assign flg_s.lobat    = sync_in[NUM_CH + OFS_LOBAT];
  assign flg_s.por      = sync_in[NUM_CH + OFS_POR];
  assign flg_s.started  = sync_in[NUM_CH + OFS_STARTED];
  assign flg_s.stby_lvl = sync_in[NUM_CH + OFS_STBY];
  assign flg_s.legacy   = sync_in[NUM_CH + OFS_LEGACY];

  diag_cfg_regs #(.NUM_CH(NUM_CH), .CFG_DW(CFG_DW)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .en_q    (en_q),
    .route_q (route_q)
  );

  diag_clip_router #(.NUM_CH(NUM_CH)) u_router (
    .clip    (clip_s),
    .route   (route_q),
    .to_diag (clip_to_diag),
    .to_stby (clip_to_stby)
  );

  diag_por_tracker u_por (
    .clk        (clk),
    .rst        (rst),
    .por_s      (flg_s.por),
    .started_s  (flg_s.started),
    .por_active (por_active),
    .por_hold_q (por_hold_q)
  );

  // Fault and standby selection
  always_comb begin
    bus_fault = por_active | flg_s.lobat | flg_s.hibat | flg_s.ovp
              | (flg_s.tempw   & en_q[EN_TEMPW])
              | (flg_s.shrt    & en_q[EN_SHORT])
              | (flg_s.misscur & en_q[EN_MISSCUR])
              | clip_to_diag;
    legacy_fault = flg_s.lobat | flg_s.hibat | flg_s.ovp | flg_s.tempw
                 | flg_s.shrt | flg_s.misscur | (|clip_s);
    fault          = flg_s.legacy ? legacy_fault : bus_fault;
    stby_clip_mode = ~flg_s.legacy & en_q[EN_STBY_CLIP];
    stby_next      = stby_clip_mode ? ~clip_to_stby : flg_s.stby_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      diag_n <= 1'b0;
      stby_n <= 1'b1;
    end else begin
      diag_n <= ~fault;
      stby_n <= stby_next;
    end
  end

endmodule

// File: rtl/amp_diag_agg_chk.sv
module amp_diag_agg_chk
  import diag_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CFG_DW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              diag_n,
  input logic              stby_n,
  input diag_flags_t       flg_s,
  input logic [NUM_CH-1:0] clip_s,
  input logic              por_hold_q,
  input logic              cfg_we,
  input logic              cfg_addr,
  input logic [CFG_DW-1:0] cfg_wdata,
  input logic [EN_W-1:0]   en_q
);

  // R1: first edge after reset release sees the reset pin levels
  a_r1_reset_value: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> (!diag_n && stby_n));

  // R2: with nothing contributing, the pin is released next edge
  a_r2_release: assert property (@(posedge clk) disable iff (rst)
    (!flg_s.legacy && !flg_s.por && !(por_hold_q && !flg_s.started) &&
     !flg_s.lobat && !flg_s.hibat && !flg_s.ovp && !flg_s.tempw &&
     !flg_s.shrt && !flg_s.misscur && (clip_s == '0)) |=> diag_n);

  // R3: supply faults cannot be masked
  a_r3_fixed_flags: assert property (@(posedge clk) disable iff (rst)
    (!flg_s.legacy && (flg_s.lobat || flg_s.hibat || flg_s.ovp)) |=> !diag_n);

  // R4: power-up hold keeps the pin low until start-up
  a_r4_por_hold: assert property (@(posedge clk) disable iff (rst)
    (!flg_s.legacy && por_hold_q && !flg_s.started) |=> !diag_n);

  // R8: legacy clip is unmasked
  a_r8_legacy_clip: assert property (@(posedge clk) disable iff (rst)
    (flg_s.legacy && (clip_s != '0)) |=> !diag_n);

  // R9: legacy standby pin follows its control level
  a_r9_legacy_pass: assert property (@(posedge clk) disable iff (rst)
    flg_s.legacy |=> (stby_n == $past(flg_s.stby_lvl)));

  // R10: enable register takes the written value
  a_r10_en_write: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == CFG_ADDR_ENABLE) |=> (en_q == $past(cfg_wdata[EN_W-1:0])));

endmodule

bind amp_diag_agg amp_diag_agg_chk #(.NUM_CH(NUM_CH), .CFG_DW(CFG_DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .diag_n     (diag_n),
  .stby_n     (stby_n),
  .flg_s      (flg_s),
  .clip_s     (clip_s),
  .por_hold_q (por_hold_q),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .en_q       (en_q)
);

// File: tb/amp_diag_agg_tb.sv
`timescale 1ns/1ps
module amp_diag_agg_tb;

  localparam int NUM_CH = 4;
  localparam int CFG_DW = 8;

  typedef struct packed {
    bit       leg;
    bit       por;
    bit       lb;
    bit       hb;
    bit       ov;
    bit       tw;
    bit       sh;
    bit       mc;
    bit [3:0] clip;
    bit       st;
    bit       sc;
    bit [3:0] en;
    bit [7:0] rt;
    bit       ed;
    bit       es;
    int       req;
  } vec_t;

  localparam int NV = 28;
  // fields: leg por lb hb ov tw sh mc clip st sc en rt | exp diag_n exp stby_n | req
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b1,1'b1,4'h0,8'h00,1'b1,1'b1,4},  // R4 start clears hold
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b1,1'b1,4'h0,8'h00,1'b0,1'b1,3},  // R3 lobat
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'h0,1'b1,1'b1,4'h0,8'h00,1'b0,1'b1,3},  // R3 hibat
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,4'h0,1'b1,1'b1,4'h0,8'h00,1'b0,1'b1,3},  // R3 ovp
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,1'b1,1'b1,4'h0,8'h00,1'b1,1'b1,5},  // R5 tempw masked
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,1'b1,1'b1,4'h1,8'h00,1'b0,1'b1,5},  // R5 tempw enabled
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0,1'b1,1'b1,4'h1,8'h00,1'b1,1'b1,5},  // R5 short, wrong enable
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0,1'b1,1'b1,4'h2,8'h00,1'b0,1'b1,5},  // R5 short enabled
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'h0,1'b1,1'b1,4'h2,8'h00,1'b1,1'b1,5},  // R5 misscur masked
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'h0,1'b1,1'b1,4'h4,8'h00,1'b0,1'b1,5},  // R5 misscur enabled
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'h1,1'b1,1'b1,4'h8,8'h01,1'b0,1'b1,7},  // R7 ch0 to diag
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'h1,1'b1,1'b1,4'h8,8'h02,1'b1,1'b0,6},  // R6 ch0 to stby
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'h4,1'b1,1'b1,4'h8,8'h02,1'b1,1'b1,7},  // R7 ch2 off
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'h4,1'b1,1'b1,4'h8,8'h30,1'b0,1'b0,7},  // R7 ch2 both
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'h8,1'b1,1'b0,4'h0,8'h80,1'b1,1'b0,9},  // R9 passthrough low
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'h1,1'b1,1'b1,4'h0,8'h02,1'b1,1'b1,9},  // R9 not a clip output
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,1'b1,1'b1,4'h0,8'h00,1'b0,1'b1,8},  // R8 legacy tempw
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'h2,1'b1,1'b1,4'h8,8'h00,1'b0,1'b1,8},  // R8 legacy clip
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b1,1'b0,4'h8,8'hFF,1'b1,1'b0,9},  // R9 legacy passthrough
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0,1'b1,1'b1,4'h0,8'h00,1'b0,1'b1,8},  // R8 legacy short
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'h0,1'b1,1'b1,4'h0,8'h00,1'b0,1'b1,8},  // R8 legacy misscur
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,1'b1,1'b1,4'h1,8'h00,1'b0,1'b1,3},  // R3 OR of two
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'hF,1'b1,1'b1,4'h8,8'hAA,1'b1,1'b0,6},  // R6 all to stby
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b1,1'b1,4'h0,8'h00,1'b0,1'b1,4},  // R4 por asserted
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,1'b1,4'h0,8'h00,1'b0,1'b1,4},  // R4 held
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,1'b1,4'h0,8'h00,1'b1,1'b1,8},  // R8 hold hidden
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,1'b1,4'h0,8'h00,1'b0,1'b1,4},  // R4 still held
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b1,1'b1,4'h0,8'h00,1'b1,1'b1,4}   // R4 released
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              legacy_mode = 1'b0;
  logic              standby_ctrl = 1'b1;
  logic              amp_started = 1'b0;
  logic              por_flag = 1'b0;
  logic              lobat_flag = 1'b0;
  logic              hibat_flag = 1'b0;
  logic              ovp_flag = 1'b0;
  logic              tempw_flag = 1'b0;
  logic              short_flag = 1'b0;
  logic              misscur_flag = 1'b0;
  logic [NUM_CH-1:0] clip_flag = '0;
  logic              cfg_we = 1'b0;
  logic              cfg_addr = 1'b0;
  logic [CFG_DW-1:0] cfg_wdata = '0;
  logic              diag_n;
  logic              stby_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  amp_diag_agg #(.NUM_CH(NUM_CH), .CFG_DW(CFG_DW)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .legacy_mode  (legacy_mode),
    .standby_ctrl (standby_ctrl),
    .amp_started  (amp_started),
    .por_flag     (por_flag),
    .lobat_flag   (lobat_flag),
    .hibat_flag   (hibat_flag),
    .ovp_flag     (ovp_flag),
    .tempw_flag   (tempw_flag),
    .short_flag   (short_flag),
    .misscur_flag (misscur_flag),
    .clip_flag    (clip_flag),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .diag_n       (diag_n),
    .stby_n       (stby_n)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input logic a, input logic [CFG_DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic apply(input vec_t v);
    cfg_write(1'b0, {{(CFG_DW-4){1'b0}}, v.en});
    cfg_write(1'b1, v.rt);
    legacy_mode = v.leg; por_flag = v.por; lobat_flag = v.lb;
    hibat_flag = v.hb; ovp_flag = v.ov; tempw_flag = v.tw;
    short_flag = v.sh; misscur_flag = v.mc; clip_flag = v.clip;
    amp_started = v.st; standby_ctrl = v.sc;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: levels during reset
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 diag_n in reset", diag_n, 1'b0);
    check("R1 stby_n in reset", stby_n, 1'b1);
    rst = 1'b0;
    // R4: hold stays with no start-up
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R4 hold after reset", diag_n, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      check($sformatf("R%0d vec %0d diag_n", TBL[i].req, i), diag_n, TBL[i].ed);
      check($sformatf("R%0d vec %0d stby_n", TBL[i].req, i), stby_n, TBL[i].es);
    end

    // R2: exact latency from a quiet bus-mode state
    apply('{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b1,1'b1,4'h0,8'h00,1'b1,1'b1,2});
    check("R2 quiet", diag_n, 1'b1);
    lobat_flag = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R2 not yet after two edges", diag_n, 1'b1);
    @(posedge clk);
    @(negedge clk);
    check("R2 low at third edge", diag_n, 1'b0);
    lobat_flag = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 released", diag_n, 1'b1);

    // R10: enable write timing with tempw held high
    tempw_flag = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 masked before write", diag_n, 1'b1);
    cfg_we = 1'b1; cfg_addr = 1'b0; cfg_wdata = 8'h01;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    check("R10 one edge after write", diag_n, 1'b1);
    @(posedge clk);
    @(negedge clk);
    check("R10 second edge after write", diag_n, 1'b0);

    // R1: reset again restores levels and clears enables
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 diag_n on second reset", diag_n, 1'b0);
    check("R1 stby_n on second reset", stby_n, 1'b1);
    rst = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 enables cleared, tempw masked", diag_n, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule